// File: doc/BRIEF.md
# Digital Potentiometer Wiper Command Executor

This block keeps the wiper settings of a three-channel digital potentiometer and carries out short 4-bit commands on them. Two wipers are 9 bits wide and one is 7 bits wide. Each wiper has its own nonvolatile shadow word. A command acts on one wiper, chosen by a 2-bit select, or on all three at once. The commands step a wiper up or down by one code, or by 6 dB (a one-bit shift). Other commands copy a shadow word into its wiper, copy a wiper into its shadow word, or reload every wiper from the shadow array.

Writing a shadow word and refreshing all wipers both run an internal nonvolatile cycle. The cycle lasts a fixed number of clock cycles, and the `busy` flag stays high for all of it. A controller polls that flag before it sends the next command, and any command that arrives while the flag is high is dropped. A copy from a shadow word into a wiper leaves the block in a read-power state that only a NOP clears. A hardware reload input starts the same refresh cycle as the reset command. The nonvolatile array is modelled behaviourally inside the block, and the shadow words come up at mid-scale when the block is reset.

Top module: `wiper_cmd_exec`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, all three wipers read 0 and `busy_o` and `rd_state_o` are low. The shadow words hold mid-scale: 256 for wipers 0 and 1, and 64 for wiper 2.
- R2: Opcode 4'b1010 raises the selected wiper by one code and opcode 4'b0101 lowers it by one code. The result is visible on the wiper output one clock after the command is accepted. The value stops at full scale and at 0 and never wraps. Select value 0, 1 or 2 picks wiper 0, 1 or 2, and the other wipers do not change.
- R3: Opcode 4'b1000 doubles the selected wiper. A value of 0 becomes 1, and any value above half of full scale becomes full scale. Opcode 4'b0011 halves the selected wiper by shifting it right once.
- R4: Opcodes 4'b1011 (up one code), 4'b0110 (down one code), 4'b1001 (up 6 dB) and 4'b0100 (down 6 dB) apply the same change to all three wipers and ignore the select.
- R5: Wipers 0 and 1 have a full scale of 511. Wiper 2 has a full scale of 127.
- R6: Opcode 4'b0010 copies the selected wiper into its shadow word. `busy_o` rises one clock after the command is accepted and stays high for exactly NV_LAT clocks. The wiper value does not change.
- R7: Opcode 4'b0001 loads the selected wiper from its shadow word one clock after the command is accepted. It does not raise `busy_o` and it sets `rd_state_o`.
- R8: `rd_state_o` clears only when a NOP (4'b0000) is accepted. No other command clears it, and a NOP changes nothing else.
- R9: Opcode 4'b0111 raises `busy_o` for exactly NV_LAT clocks. When the cycle ends, it loads every wiper from its shadow word.
- R10: A one-clock pulse on `hw_reload_i` while the block is idle starts the same refresh cycle as R9. If a command is presented in the same clock as the pulse, the command is dropped.
- R11: A command presented while `busy_o` is high has no effect on the wipers or the shadow words, and it does not change how long the cycle lasts.
- R12: The reserved opcodes 4'b1100 to 4'b1111 have no effect. A single-wiper opcode with select value 3 also has no effect and does not raise `busy_o`.
- R13: Step and shift commands never change a shadow word, and a store never changes a wiper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_reload_i | input | 1 | Start a refresh of all wipers from the shadow array |
| cmd_valid_i | input | 1 | Command strobe, one clock per command |
| cmd_op_i | input | 4 | Command opcode |
| cmd_sel_i | input | 2 | Wiper select for single-wiper opcodes |
| busy_o | output | 1 | High while a nonvolatile cycle runs |
| rd_state_o | output | 1 | Read-power state entered by a restore |
| wiper0_o | output | WIDE_W | Wiper 0 setting |
| wiper1_o | output | WIDE_W | Wiper 1 setting |
| wiper2_o | output | NARROW_W | Wiper 2 setting |

## Verification
The assertions check the following on every clock:
- the wipers hold still while a nonvolatile cycle runs;
- the shadow array is written only during a cycle;
- a refresh loads exactly the shadow contents;
- the read-power flag falls only after an accepted NOP;
- all-wiper steps never wrap at full scale or at 0.

Only the bench scenarios can show the following:
- the full saturating staircase of every wiper;
- the exact busy length;
- the priority of the reload pin over a command in the same clock;
- that a shadow word survives later steps, which the bench proves by restoring it.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

  localparam int N_WIPER = 3;
  localparam int SEL_W   = 2;

  localparam logic [3:0] OP_NOP     = 4'h0;
  localparam logic [3:0] OP_RESTORE = 4'h1;
  localparam logic [3:0] OP_STORE   = 4'h2;
  localparam logic [3:0] OP_DN6_ONE = 4'h3;
  localparam logic [3:0] OP_DN6_ALL = 4'h4;
  localparam logic [3:0] OP_DN1_ONE = 4'h5;
  localparam logic [3:0] OP_DN1_ALL = 4'h6;
  localparam logic [3:0] OP_RESET   = 4'h7;
  localparam logic [3:0] OP_UP6_ONE = 4'h8;
  localparam logic [3:0] OP_UP6_ALL = 4'h9;
  localparam logic [3:0] OP_UP1_ONE = 4'hA;
  localparam logic [3:0] OP_UP1_ALL = 4'hB;

  typedef enum logic [2:0] {
    STEP_HOLD,
    STEP_UP1,
    STEP_DN1,
    STEP_UP6,
    STEP_DN6
  } step_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_STORE,
    SEQ_REFRESH
  } seq_e;

endpackage

// File: rtl/wiper_step.sv
module wiper_step
  import dpw_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [W-1:0] val_i,
  input  step_e        kind_i,
  output logic [W-1:0] val_o
);

  localparam logic [W-1:0] FULL = {W{1'b1}};
  localparam logic [W-1:0] HALF = FULL >> 1;

  always_comb begin
    val_o = val_i;
    case (kind_i)
      STEP_UP1: val_o = (val_i == FULL) ? FULL : val_i + 1'b1;
      STEP_DN1: val_o = (val_i == '0) ? '0 : val_i - 1'b1;
      STEP_UP6: begin
        if (val_i == '0)       val_o = {{(W-1){1'b0}}, 1'b1};
        else if (val_i > HALF) val_o = FULL;
        else                   val_o = {val_i[W-2:0], 1'b0};
      end
      STEP_DN6: val_o = val_i >> 1;
      default:  val_o = val_i;
    endcase
  end

endmodule

// File: rtl/nv_array.sv
module nv_array
  import dpw_pkg::*;
#(
  parameter int WIDE_W   = 9,
  parameter int NARROW_W = 7,
  parameter int NV_LAT   = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           we_i,
  input  logic [SEL_W-1:0]               addr_i,
  input  logic [WIDE_W-1:0]              wdata_i,
  output logic                           done_o,
  output logic [N_WIPER-1:0][WIDE_W-1:0] rdata_o
);

  localparam int CW = (NV_LAT > 1) ? $clog2(NV_LAT) : 1;

  logic                           active_q, active_d;
  logic [CW-1:0]                  cnt_q, cnt_d;
  logic                           we_q, we_d;
  logic [SEL_W-1:0]               addr_q, addr_d;
  logic [WIDE_W-1:0]              data_q, data_d;
  logic [N_WIPER-1:0][WIDE_W-1:0] mem_q, mem_d;
  logic                           mem_en;

  function automatic logic [WIDE_W-1:0] mid_val(input int idx);
    if (idx == N_WIPER - 1) return WIDE_W'(1) << (NARROW_W - 1);
    return WIDE_W'(1) << (WIDE_W - 1);
  endfunction

  assign done_o  = active_q && (cnt_q == '0);
  assign rdata_o = mem_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    we_d     = we_q;
    addr_d   = addr_q;
    data_d   = data_q;
    mem_d    = mem_q;
    mem_en   = 1'b0;
    if (!active_q) begin
      if (start_i) begin
        active_d = 1'b1;
        cnt_d    = CW'(NV_LAT - 1);
        we_d     = we_i;
        addr_d   = addr_i;
        data_d   = wdata_i;
      end
    end else if (cnt_q == '0) begin
      active_d = 1'b0;
      if (we_q) begin
        mem_d[addr_q] = data_q;
        mem_en        = 1'b1;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      we_q     <= we_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_WIPER; i++) mem_q[i] <= mid_val(i);
    end else if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  // R13
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> $stable(mem_q));

endmodule

// File: rtl/wiper_cmd_exec.sv
module wiper_cmd_exec
  import dpw_pkg::*;
#(
  parameter int WIDE_W   = 9,
  parameter int NARROW_W = 7,
  parameter int NV_LAT   = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hw_reload_i,
  input  logic                cmd_valid_i,
  input  logic [3:0]          cmd_op_i,
  input  logic [SEL_W-1:0]    cmd_sel_i,
  output logic                busy_o,
  output logic                rd_state_o,
  output logic [WIDE_W-1:0]   wiper0_o,
  output logic [WIDE_W-1:0]   wiper1_o,
  output logic [NARROW_W-1:0] wiper2_o
);

  localparam int MAXW = WIDE_W;

  seq_e                         seq_q, seq_d;
  logic [N_WIPER-1:0][MAXW-1:0] wip_q, wip_d, step_val, nv_rdata;
  logic [N_WIPER-1:0]           wip_en;
  logic                         rd_q, rd_d;
  logic                         accept, reload_go, sel_ok, one_op, all_op;
  step_e                        kind;
  step_e                        kind_w [N_WIPER];
  logic                         nv_start, nv_we, nv_done;
  logic [MAXW-1:0]              nv_wdata;

  assign accept    = cmd_valid_i && (seq_q == SEQ_IDLE) && !hw_reload_i;
  assign reload_go = hw_reload_i && (seq_q == SEQ_IDLE);
  assign sel_ok    = cmd_sel_i < SEL_W'(N_WIPER);

  // opcode decode into a step kind and a scope
  always_comb begin
    kind   = STEP_HOLD;
    one_op = 1'b0;
    all_op = 1'b0;
    case (cmd_op_i)
      OP_UP1_ONE: begin kind = STEP_UP1; one_op = 1'b1; end
      OP_DN1_ONE: begin kind = STEP_DN1; one_op = 1'b1; end
      OP_UP6_ONE: begin kind = STEP_UP6; one_op = 1'b1; end
      OP_DN6_ONE: begin kind = STEP_DN6; one_op = 1'b1; end
      OP_UP1_ALL: begin kind = STEP_UP1; all_op = 1'b1; end
      OP_DN1_ALL: begin kind = STEP_DN1; all_op = 1'b1; end
      OP_UP6_ALL: begin kind = STEP_UP6; all_op = 1'b1; end
      OP_DN6_ALL: begin kind = STEP_DN6; all_op = 1'b1; end
      default: ;
    endcase
  end

  // nonvolatile cycle launch
  always_comb begin
    nv_start = 1'b0;
    nv_we    = 1'b0;
    nv_wdata = wip_q[cmd_sel_i];
    if (reload_go) begin
      nv_start = 1'b1;
    end else if (accept && (cmd_op_i == OP_STORE) && sel_ok) begin
      nv_start = 1'b1;
      nv_we    = 1'b1;
    end else if (accept && (cmd_op_i == OP_RESET)) begin
      nv_start = 1'b1;
    end
  end

  nv_array #(
    .WIDE_W  (WIDE_W),
    .NARROW_W(NARROW_W),
    .NV_LAT  (NV_LAT)
  ) u_nv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(nv_start),
    .we_i   (nv_we),
    .addr_i (cmd_sel_i),
    .wdata_i(nv_wdata),
    .done_o (nv_done),
    .rdata_o(nv_rdata)
  );

  for (genvar gi = 0; gi < N_WIPER; gi++) begin : g_wip
    localparam int WW = (gi == N_WIPER - 1) ? NARROW_W : WIDE_W;
    always_comb begin
      kind_w[gi] = STEP_HOLD;
      if (accept && (all_op || (one_op && sel_ok && (cmd_sel_i == SEL_W'(gi)))))
        kind_w[gi] = kind;
    end
    wiper_step #(.W(WW)) u_step (
      .val_i (wip_q[gi][WW-1:0]),
      .kind_i(kind_w[gi]),
      .val_o (step_val[gi][WW-1:0])
    );
    if (WW < MAXW) begin : g_pad
      assign step_val[gi][MAXW-1:WW] = '0;
    end
  end

  // sequencer and wiper next state
  always_comb begin
    seq_d = seq_q;
    case (seq_q)
      SEQ_IDLE:    if (nv_start) seq_d = nv_we ? SEQ_STORE : SEQ_REFRESH;
      SEQ_STORE:   if (nv_done) seq_d = SEQ_IDLE;
      SEQ_REFRESH: if (nv_done) seq_d = SEQ_IDLE;
      default:     seq_d = SEQ_IDLE;
    endcase
    for (int i = 0; i < N_WIPER; i++) begin
      wip_d[i]  = step_val[i];
      wip_en[i] = (kind_w[i] != STEP_HOLD);
      if (accept && (cmd_op_i == OP_RESTORE) && sel_ok && (cmd_sel_i == SEL_W'(i))) begin
        wip_d[i]  = nv_rdata[i];
        wip_en[i] = 1'b1;
      end
      if ((seq_q == SEQ_REFRESH) && nv_done) begin
        wip_d[i]  = nv_rdata[i];
        wip_en[i] = 1'b1;
      end
    end
    rd_d = rd_q;
    if (accept && (cmd_op_i == OP_RESTORE) && sel_ok) rd_d = 1'b1;
    else if (accept && (cmd_op_i == OP_NOP))          rd_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= SEQ_IDLE;
      rd_q  <= 1'b0;
    end else begin
      seq_q <= seq_d;
      rd_q  <= rd_d;
    end
  end

  for (genvar gr = 0; gr < N_WIPER; gr++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         wip_q[gr] <= '0;
      else if (wip_en[gr]) wip_q[gr] <= wip_d[gr];
    end
  end

  assign busy_o     = (seq_q != SEQ_IDLE);
  assign rd_state_o = rd_q;
  assign wiper0_o   = wip_q[0];
  assign wiper1_o   = wip_q[1];
  assign wiper2_o   = wip_q[N_WIPER-1][NARROW_W-1:0];

  // R11
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !nv_done) |=> $stable(wip_q));

  // R9
  refresh_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seq_q == SEQ_REFRESH) && nv_done) |=> (wip_q == $past(nv_rdata)));

  // R8
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_q) |-> $past(cmd_valid_i && (cmd_op_i == OP_NOP) && !busy_o && !hw_reload_i));

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (cmd_op_i == OP_UP1_ALL) && (wiper2_o == {NARROW_W{1'b1}}))
      |=> (wiper2_o == {NARROW_W{1'b1}}));

  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (cmd_op_i == OP_DN1_ALL) && (wiper0_o == '0)) |=> (wiper0_o == '0));

endmodule

// File: tb/wiper_cmd_exec_tb_top.sv
module wiper_cmd_exec_tb_top;

  localparam int LAT = 6;
  localparam logic [3:0] C_NOP = 4'h0, C_RST1 = 4'h1, C_STO = 4'h2, C_D6 = 4'h3,
                         C_D6A = 4'h4, C_D1 = 4'h5, C_D1A = 4'h6, C_RALL = 4'h7,
                         C_U6 = 4'h8, C_U6A = 4'h9, C_U1 = 4'hA, C_U1A = 4'hB;

  logic       clk, rst_n, hw_reload, cmd_valid;
  logic [3:0] cmd_op;
  logic [1:0] cmd_sel;
  logic       busy, rd_state;
  logic [8:0] w0, w1;
  logic [6:0] w2;

  int n_chk, n_fail;
  int m [3];
  int sh [3];
  bit finished;

  wiper_cmd_exec #(.WIDE_W(9), .NARROW_W(7), .NV_LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_reload_i(hw_reload),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_sel_i(cmd_sel),
    .busy_o(busy), .rd_state_o(rd_state),
    .wiper0_o(w0), .wiper1_o(w1), .wiper2_o(w2)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int fs_of(input int i);
    return (i == 2) ? 127 : 511;
  endfunction

  function automatic int model(input int v, input logic [3:0] op, input int fs);
    case (op)
      C_U1, C_U1A: return (v == fs) ? fs : v + 1;
      C_D1, C_D1A: return (v == 0) ? 0 : v - 1;
      C_U6, C_U6A: return (v == 0) ? 1 : ((v > fs / 2) ? fs : v * 2);
      C_D6, C_D6A: return v / 2;
      default:     return v;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_wipers(input string tag);
    check(int'(w0) == m[0], tag, int'(w0), m[0]);
    check(int'(w1) == m[1], tag, int'(w1), m[1]);
    check(int'(w2) == m[2], tag, int'(w2), m[2]);
  endtask

  task automatic issue(input logic [3:0] op, input logic [1:0] sel);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // apply a step command and its model to the wipers it selects
  task automatic step_cmd(input logic [3:0] op, input int sel, input bit all, input string tag);
    issue(op, 2'(sel));
    for (int i = 0; i < 3; i++)
      if (all || (i == sel)) m[i] = model(m[i], op, fs_of(i));
    chk_wipers(tag);
  endtask

  // count busy cycles, optionally injecting a command in the first one
  task automatic busy_len(input bit inject, output int n);
    n = 0;
    while (busy && n < 100) begin
      if (inject && n == 0) begin cmd_valid = 1'b1; cmd_op = C_U1A; cmd_sel = 2'd0; end
      else cmd_valid = 1'b0;
      n++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    int n;
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; hw_reload = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m = '{0, 0, 0}; sh = '{256, 256, 64};
    chk_wipers("R1 reset wipers");
    check(!busy, "R1 busy", busy, 0);
    check(!rd_state, "R1 rd_state", rd_state, 0);

    // R2 R3 R5: per-wiper sweeps over the whole range and past both ends
    for (int s = 0; s < 3; s++) begin
      int fs = fs_of(s);
      int wb = (s == 2) ? 7 : 9;
      for (int k = 0; k <= fs + 1; k++) step_cmd(C_U1, s, 0, "R2 R5 up one step");
      for (int k = 0; k <= fs + 1; k++) step_cmd(C_D1, s, 0, "R2 down one step");
      for (int k = 0; k <= wb + 1; k++) step_cmd(C_U6, s, 0, "R3 R5 up 6dB");
      for (int k = 0; k <= wb + 1; k++) step_cmd(C_D6, s, 0, "R3 down 6dB");
    end

    // R4: all-wiper variants, select ignored
    for (int k = 0; k < 130; k++) step_cmd(C_U1A, 3, 1, "R4 all up one");
    for (int k = 0; k < 4; k++)   step_cmd(C_U6A, 1, 1, "R4 all up 6dB");
    for (int k = 0; k < 3; k++)   step_cmd(C_D6A, 2, 1, "R4 all down 6dB");
    for (int k = 0; k < 70; k++)  step_cmd(C_D1A, 0, 1, "R4 all down one");

    // R12: reserved opcodes and select 3
    for (int op = 12; op < 16; op++) begin
      issue(4'(op), 2'd0);
      chk_wipers("R12 reserved opcode");
      check(!busy, "R12 reserved no busy", busy, 0);
    end
    issue(C_U1, 2'd3);
    chk_wipers("R12 select 3 step");
    issue(C_STO, 2'd3);
    check(!busy, "R12 select 3 store no busy", busy, 0);

    // R6 R11: store wiper 1 with a command injected while busy
    step_cmd(C_U1, 1, 0, "R2 prep");
    issue(C_STO, 2'd1);
    check(busy, "R6 busy rises", busy, 1);
    busy_len(1, n);
    check(n == LAT, "R6 R11 busy length", n, LAT);
    sh[1] = m[1];
    chk_wipers("R11 R6 wipers unchanged by store and ignored cmd");

    // R6: plain store of wiper 2
    issue(C_STO, 2'd2);
    busy_len(0, n);
    check(n == LAT, "R6 busy length", n, LAT);
    sh[2] = m[2];

    // R13: steps after the store do not touch shadow; restore proves it
    step_cmd(C_U6A, 0, 1, "R13 step after store");
    step_cmd(C_U1, 1, 0, "R13 step after store");
    issue(C_RST1, 2'd1);
    m[1] = sh[1];
    chk_wipers("R7 R13 restore wiper 1");
    check(!busy, "R7 no busy", busy, 0);
    check(rd_state, "R7 rd_state set", rd_state, 1);
    issue(C_RST1, 2'd2);
    m[2] = sh[2];
    chk_wipers("R7 restore wiper 2");
    issue(C_RST1, 2'd0);
    m[0] = sh[0];
    chk_wipers("R7 restore wiper 0 mid-scale R1");

    // R8: only NOP clears the read state
    step_cmd(C_U1A, 0, 1, "R8 step keeps state");
    check(rd_state, "R8 rd_state after step", rd_state, 1);
    issue(C_RALL, 2'd0);
    busy_len(0, n);
    check(rd_state, "R8 rd_state after reset cmd", rd_state, 1);
    m = sh;
    chk_wipers("R9 reset cmd reload");
    check(n == LAT, "R9 busy length", n, LAT);
    issue(C_NOP, 2'd0);
    check(!rd_state, "R8 NOP clears", rd_state, 0);
    chk_wipers("R8 NOP no effect");

    // R9: wipers hold during refresh, load at its end
    step_cmd(C_D6A, 0, 1, "R9 prep");
    issue(C_RALL, 2'd3);
    chk_wipers("R9 hold during cycle");
    busy_len(0, n);
    m = sh;
    chk_wipers("R9 reload at end");

    // R10: reload pin with a simultaneous command
    step_cmd(C_U1A, 0, 1, "R10 prep");
    @(negedge clk);
    hw_reload = 1'b1; cmd_valid = 1'b1; cmd_op = C_U1A; cmd_sel = 2'd0;
    @(negedge clk);
    hw_reload = 1'b0; cmd_valid = 1'b0;
    check(busy, "R10 busy rises", busy, 1);
    busy_len(0, n);
    check(n == LAT, "R10 busy length", n, LAT);
    m = sh;
    chk_wipers("R10 reload from shadow");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule